// File: doc/BRIEF.md
# Fractional clock enable generator

This block issues a one-cycle enable pulse on a fast system clock. Over time the pulses arrive at a rational fraction STEP/MOD of the clock rate. The fraction need not divide evenly, so a 50 MHz clock can yield a 25.175 MHz average pixel rate with STEP = 1007 and MOD = 2000. Only integer arithmetic is used. A phase register advances by STEP on every active cycle and wraps modulo MOD. A pulse marks each wrap.

The spacing between pulses switches between the two whole-cycle values that lie on either side of MOD/STEP. The long-run rate is exact, but each single period jitters. All consumers stay on the fast clock and use the pulse to qualify their work; no new clock is created. A second output flips on every pulse. It gives a square-ish wave at half the pulse rate, meant only for probing.

Top module: `frac_enable_gen`

## Requirements
- R1: After a synchronous reset, the n-th clock edge with run high (n counted from 0) leaves tick equal to floor((n+1)*STEP/MOD) - floor(n*STEP/MOD), registered so it is visible for the cycle after that edge.
- R2: In any MOD consecutive run-high cycles starting right after reset, exactly STEP ticks occur.
- R3: When run stays high, the distance between consecutive ticks is always floor(MOD/STEP) or ceil(MOD/STEP) cycles.
- R4: An edge that samples rst high clears the phase to zero, sets tick low and sets tick_toggle low, whatever run is. The sequence then restarts from n = 0.
- R5: An edge that samples run low (with rst low) leaves tick low and keeps the phase unchanged. The sequence resumes where it stopped once run returns high.
- R6: When STEP equals MOD, every edge that samples run high (with rst low) gives a tick.
- R7: tick_toggle inverts on every edge that raises tick and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Global run qualifier; when low, the phase freezes |
| tick | output | 1 | One-cycle enable pulse |
| tick_toggle | output | 1 | Inverts on each tick, for observation only |

## Verification
A small 3/7 ratio is driven from a table that mixes runs of active cycles with idle gaps. This separates correct phase holding from a phase that drifts or resets during idle cycles. The 1007/2000 ratio runs continuously for one full modulus window against an arithmetic model, which exposes errors in the wrap comparison, the subtraction or the step value through the pulse count and the pulse spacing. A 5/5 instance checks the full-rate variant. A reset applied while run is high checks reset priority and the restart of the sequence.

// File: rtl/frac_enable_pkg.sv
package frac_enable_pkg;

   // Phase register width: must hold phase + STEP before the wrap.
   function automatic int phase_width(input int modulus, input int step);
      return $clog2(modulus + step);
   endfunction

endpackage

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
   parameter int STEP = 1007,
   parameter int MOD  = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   import frac_enable_pkg::*;

   localparam int PW = phase_width(MOD, STEP);
   localparam logic [PW-1:0] STEP_V = PW'(STEP);
   localparam logic [PW-1:0] MOD_V  = PW'(MOD);

   logic [PW-1:0] phase_q;
   logic [PW-1:0] sum;
   logic          wrap;

   always_comb begin
      sum  = phase_q + STEP_V;
      wrap = (sum >= MOD_V);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         tick    <= 1'b0;
      end else if (run) begin
         phase_q <= wrap ? (sum - MOD_V) : sum;
         tick    <= wrap;
      end else begin
         tick    <= 1'b0;
      end
   end

   assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (rst)
      phase_q < MOD_V);

   assert_reset_clears_R4: assert property (@(posedge clk)
      rst |=> (phase_q == '0) && !tick);

   assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(phase_q) && !tick);

endmodule

// File: rtl/frac_full_rate.sv
module frac_full_rate (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   always_ff @(posedge clk) begin
      if (rst) tick <= 1'b0;
      else     tick <= run;
   end

   assert_every_cycle_R6: assert property (@(posedge clk) disable iff (rst)
      run |=> tick);

endmodule

// File: rtl/frac_toggle_obs.sv
module frac_toggle_obs (
   input  logic clk,
   input  logic rst,
   input  logic tick_d,
   input  logic tick_q,
   output logic tog
);
   always_ff @(posedge clk) begin
      if (rst)         tog <= 1'b0;
      else if (tick_d) tog <= ~tog;
   end

   assert_toggle_follows_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (tick_q == (tog != $past(tog))));

endmodule

// File: rtl/frac_enable_gen.sv
module frac_enable_gen #(
   parameter int STEP = 1007,
   parameter int MOD  = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick,
   output logic tick_toggle
);
   localparam bit FULL_RATE = (STEP == MOD);

   initial begin
      if (STEP <= 0 || STEP > MOD)
         $error("frac_enable_gen: need 0 < STEP <= MOD");
   end

   logic tick_q;
   logic tick_d;

   generate
      if (FULL_RATE) begin : g_full
         frac_full_rate u_core (
            .clk  (clk),
            .rst  (rst),
            .run  (run),
            .tick (tick_q)
         );
         assign tick_d = run;
      end else begin : g_frac
         frac_phase_acc #(.STEP(STEP), .MOD(MOD)) u_core (
            .clk  (clk),
            .rst  (rst),
            .run  (run),
            .tick (tick_q)
         );
         // Next-edge tick value, recomputed here for the toggle stage.
         logic [frac_enable_pkg::phase_width(MOD, STEP)-1:0] ph_mirror;
         always_ff @(posedge clk) begin
            if (rst)      ph_mirror <= '0;
            else if (run) ph_mirror <= (ph_mirror + STEP >= MOD) ?
                                       ph_mirror + STEP - MOD : ph_mirror + STEP;
         end
         assign tick_d = run && ((ph_mirror + STEP) >= MOD);
      end
   endgenerate

   frac_toggle_obs u_obs (
      .clk    (clk),
      .rst    (rst),
      .tick_d (tick_d),
      .tick_q (tick_q),
      .tog    (tick_toggle)
   );

   assign tick = tick_q;

   assert_no_tick_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !run |=> !tick);

endmodule

// File: tb/test_frac_enable_gen.sv
module test_frac_enable_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed { logic run; logic exp_tick; } vec_t;
   localparam int NV = 13;
   // 3/7 ratio; idle entries must not advance the phase.
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0}, '{1'b1,1'b0}, '{1'b1,1'b1}, '{1'b0,1'b0}, '{1'b0,1'b0},
      '{1'b1,1'b0}, '{1'b1,1'b1}, '{1'b1,1'b0}, '{1'b0,1'b0}, '{1'b1,1'b1},
      '{1'b1,1'b0}, '{1'b1,1'b0}, '{1'b1,1'b1}};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run_m = 1'b0, run_s = 1'b0, run_f = 1'b0;
   logic tick_m, tog_m, tick_s, tog_s, tick_f, tog_f;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_enable_gen i_frac_enable_gen (
      .clk(clk), .rst(rst), .run(run_m), .tick(tick_m), .tick_toggle(tog_m));
   frac_enable_gen #(.STEP(3), .MOD(7)) i_small (
      .clk(clk), .rst(rst), .run(run_s), .tick(tick_s), .tick_toggle(tog_s));
   frac_enable_gen #(.STEP(5), .MOD(5)) i_full (
      .clk(clk), .rst(rst), .run(run_f), .tick(tick_f), .tick_toggle(tog_f));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int par;
      int pulses;
      int last;
      int gap_bad;
      // Reset state (R4, R7)
      run_m = 1'b1; run_s = 1'b1; run_f = 1'b1;
      repeat (2) @(negedge clk);
      check("R4 tick_m after reset", tick_m, 0);
      check("R4 tick_s after reset", tick_s, 0);
      check("R4 tick_f after reset", tick_f, 0);
      check("R7 tog_s after reset", tog_s, 0);
      run_m = 1'b0; run_s = 1'b0; run_f = 1'b0;
      rst = 1'b0;

      // Table walk on the 3/7 instance (R1, R5, R7)
      par = 0;
      for (int i = 0; i < NV; i++) begin
         run_s = VECS[i].run;
         @(negedge clk);
         par ^= int'(VECS[i].exp_tick);
         check(VECS[i].run ? "R1 tick_s" : "R5 tick_s idle", tick_s, VECS[i].exp_tick);
         check("R7 tog_s", tog_s, par);
      end
      run_s = 1'b0;
      check("R5 tick_m idle", tick_m, 0);

      // Full-rate variant (R6)
      run_f = 1'b1; @(negedge clk); check("R6 tick_f run", tick_f, 1);
      @(negedge clk); check("R6 tick_f run again", tick_f, 1);
      check("R7 tog_f", tog_f, 0);
      run_f = 1'b0; @(negedge clk); check("R6 tick_f idle", tick_f, 0);
      run_f = 1'b1; @(negedge clk); check("R6 tick_f resume", tick_f, 1);
      run_f = 1'b0;

      // Reset with run high has priority and restarts the phase (R4)
      run_s = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R4 tick_s under reset", tick_s, 0);
      check("R4 tog_s under reset", tog_s, 0);
      rst = 1'b0;
      @(negedge clk); check("R4 restart n0", tick_s, 0);
      @(negedge clk); check("R4 restart n1", tick_s, 0);
      @(negedge clk); check("R4 restart n2", tick_s, 1);
      run_s = 1'b0;

      // Full window on 1007/2000 (R1, R2, R3)
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      run_m = 1'b1;
      pulses = 0; last = -1; gap_bad = 0;
      for (int n = 0; n < 2000; n++) begin
         @(negedge clk);
         check("R1 tick_m model", tick_m,
               ((n + 1) * 1007) / 2000 - (n * 1007) / 2000);
         if (tick_m) begin
            if (last >= 0 && (n - last < 1 || n - last > 2)) gap_bad++;
            last = n;
            pulses++;
         end
      end
      check("R2 pulses per window", pulses, 1007);
      check("R3 spacing violations", gap_bad, 0);
      run_m = 1'b0;
      @(negedge clk); check("R5 tick_m after stop", tick_m, 0);
      finish_run();
   end
endmodule